// File: doc/BRIEF.md
# Modem Status Interrupt Clear Logic

This block keeps the interrupt status for the clear-to-send (CTS) modem line of a serial port. The status logic runs on the UART clock. A set of control registers runs on a separate bus clock. Every change of level on the CTS input raises a raw status bit. Software clears that bit by writing the clear register. The write does not act on the level written. It acts only on a rising transition of a hidden internal clear latch, and hardware drops that latch back to 0 on its own once the raw status reads 0.

The block reproduces a real hazard on purpose. If a CTS change and a clear transition reach the status logic in the same UART cycle, the set wins and the status stays 1. The hidden latch then never auto-resets, so later writes of 1 have no effect. Driver software breaks out of this lock-up in two steps. It first writes 0 to the clear bit and leaves it long enough for the UART clock to sample it. It then writes 1, which produces a fresh rising transition. A mask register gates the raw status onto a masked status and a single interrupt line.

Top module: `modem_irq_clear`

## Requirements
- R1: After reset, raw status, mask, masked status and the internal clear latch are 0. Every register address reads 0 and `irq` is 0.
- R2: Both a rising and a falling level change on `cts_i` set bit 1 of the raw status. The raw status reads at address 0, and bit 1 is also visible on `raw_stat`.
- R3: Writing 1 to bit 1 of the clear register (address 3) while the raw status is 1, with no CTS change in flight, returns raw status bit 1 to 0. The status falls only on such a clear transition.
- R4: Once the raw status is 0, the internal clear latch returns to 0 by itself. After the next CTS change, a plain write of 1 clears again with no 0 written in between.
- R5: A read of the clear register address returns all zeros, whatever was written there.
- R6: When a set event and a clear transition meet in the same UART clock cycle, the status stays 1. Further writes of 1 to the clear bit leave it at 1.
- R7: From the stuck state, a write of 0 to the clear bit that lasts at least two UART clock periods, followed by a write of 1, clears the status.
- R8: From the stuck state, a 0 on the clear bit that lies entirely between two UART clock edges is not seen. A following write of 1 leaves the status at 1.
- R9: The mask register is at address 2 and stores only bit 1; its other bits read 0. The masked status, readable at address 1 and on `masked_stat`, is raw AND mask. `irq` is the OR of the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| uart_clk | input | 1 | Status logic clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| cts_i | input | 1 | CTS modem line, asynchronous |
| wr_en | input | 1 | Register write strobe, one bus cycle |
| addr | input | 2 | Register address: 0 raw, 1 masked, 2 mask, 3 clear |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data for `addr`, combinational |
| raw_stat | output | REG_W | Raw status, UART clock domain |
| masked_stat | output | REG_W | Raw status ANDed with mask |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume a fixed relation between the two clocks. No UART clock edge may coincide with a bus clock edge. This keeps `irq`, which combines state from both domains, stable at the bus edge where it is sampled. It also keeps the clear transition and the CTS set pulse aligned to whole UART cycles. The stimulus runs the UART clock at a quarter of the bus rate, with edges offset by half a bus period. Every CTS change and clear write is timed from a UART edge, so that the race case and the missed short-zero case happen in a known cycle rather than by chance.

// File: rtl/msc_pkg.sv
package msc_pkg;

    localparam int REG_ADDR_W = 2;

    // Register addresses decoded by the bus side
    typedef enum logic [REG_ADDR_W-1:0] {
        ADR_RAW      = 2'd0,
        ADR_MSK_STAT = 2'd1,
        ADR_MASK     = 2'd2,
        ADR_CLR      = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/msc_sync.sv
// Multi-stage level synchronizer, reset to zero
module msc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/msc_bus_regs.sv
// Bus clock domain: mask register, hidden clear latch, read mux
module msc_bus_regs
    import msc_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int CTS_BIT     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  bus_clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]      wdata,
    input  logic [REG_W-1:0]      raw_i,
    output logic [REG_W-1:0]      rdata,
    output logic [REG_W-1:0]      mask_o,
    output logic [REG_W-1:0]      clr_lvl_o
);

    // Only implemented status bits hold state
    localparam logic [REG_W-1:0] IMPL = REG_W'(1) << CTS_BIT;

    typedef struct packed {
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] clr_lat;
    } bst_t;

    bst_t             st_q, st_d;
    logic [REG_W-1:0] raw_b;

    msc_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_raw_sync (
        .clk   (bus_clk),
        .rst_n (rst_n),
        .d     (raw_i),
        .q     (raw_b)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && (addr == ADR_MASK)) begin
            st_d.mask = wdata & IMPL;
        end
        if (wr_en && (addr == ADR_CLR)) begin
            // Written level goes straight into the hidden latch
            st_d.clr_lat = wdata & IMPL;
        end else begin
            // Self-reset: a latch bit drops once its status reads 0
            st_d.clr_lat = st_q.clr_lat & raw_b;
        end
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            ADR_RAW:      rdata = raw_b;
            ADR_MSK_STAT: rdata = raw_b & st_q.mask;
            ADR_MASK:     rdata = st_q.mask;
            default:      rdata = '0;
        endcase
    end

    assign mask_o    = st_q.mask;
    assign clr_lvl_o = st_q.clr_lat;

endmodule

// File: rtl/msc_uart_core.sv
// UART clock domain: edge detection, clear-transition detection, status
module msc_uart_core #(
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             uart_clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] clr_lvl_i,
    output logic [REG_W-1:0] raw_o,
    output logic [REG_W-1:0] set_evt_o,
    output logic [REG_W-1:0] clr_evt_o
);

    typedef struct packed {
        logic [REG_W-1:0] src_prev;
        logic [REG_W-1:0] clr_prev;
        logic [REG_W-1:0] raw;
    } ust_t;

    ust_t             st_q, st_d;
    logic [REG_W-1:0] src_s;
    logic [REG_W-1:0] clr_s;
    logic [REG_W-1:0] set_evt;
    logic [REG_W-1:0] clr_evt;

    msc_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_src_sync (
        .clk   (uart_clk),
        .rst_n (rst_n),
        .d     (src_i),
        .q     (src_s)
    );

    msc_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_clr_sync (
        .clk   (uart_clk),
        .rst_n (rst_n),
        .d     (clr_lvl_i),
        .q     (clr_s)
    );

    // Any level change sets; only a low-to-high latch move clears
    assign set_evt = src_s ^ st_q.src_prev;
    assign clr_evt = clr_s & ~st_q.clr_prev;

    always_comb begin
        st_d          = st_q;
        st_d.src_prev = src_s;
        st_d.clr_prev = clr_s;
        // Set has priority over a clear in the same cycle
        st_d.raw      = set_evt | (st_q.raw & ~clr_evt);
    end

    always_ff @(posedge uart_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o     = st_q.raw;
    assign set_evt_o = set_evt;
    assign clr_evt_o = clr_evt;

endmodule

// File: rtl/modem_irq_clear.sv
module modem_irq_clear
    import msc_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int CTS_BIT     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  bus_clk,
    input  logic                  uart_clk,
    input  logic                  rst_n,
    input  logic                  cts_i,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    output logic [REG_W-1:0]      raw_stat,
    output logic [REG_W-1:0]      masked_stat,
    output logic                  irq
);

    logic [REG_W-1:0] src_vec;
    logic [REG_W-1:0] raw;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] clr_lvl;
    logic [REG_W-1:0] set_evt;
    logic [REG_W-1:0] clr_evt;

    // Route the CTS line onto its status bit; other sources are absent
    for (genvar i = 0; i < REG_W; i++) begin : g_src
        if (i == CTS_BIT) begin : g_cts
            assign src_vec[i] = cts_i;
        end else begin : g_none
            assign src_vec[i] = 1'b0;
        end
    end

    msc_bus_regs #(
        .REG_W       (REG_W),
        .CTS_BIT     (CTS_BIT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_regs (
        .bus_clk   (bus_clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .raw_i     (raw),
        .rdata     (rdata),
        .mask_o    (mask),
        .clr_lvl_o (clr_lvl)
    );

    msc_uart_core #(
        .REG_W       (REG_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_core (
        .uart_clk  (uart_clk),
        .rst_n     (rst_n),
        .src_i     (src_vec),
        .clr_lvl_i (clr_lvl),
        .raw_o     (raw),
        .set_evt_o (set_evt),
        .clr_evt_o (clr_evt)
    );

    assign raw_stat    = raw;
    assign masked_stat = raw & mask;
    assign irq         = |masked_stat;

endmodule

// File: rtl/msc_checker.sv
module msc_checker
    import msc_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic                  bus_clk,
    input logic                  uart_clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] addr,
    input logic [REG_W-1:0]      rdata,
    input logic [REG_W-1:0]      raw_stat,
    input logic                  irq,
    input logic [REG_W-1:0]      set_evt,
    input logic [REG_W-1:0]      clr_evt
);

    // R2: a detected level change leaves its status bit at 1
    assert_edge_sets_R2: assert property (@(posedge uart_clk) disable iff (!rst_n)
        (set_evt != '0) |=> ((raw_stat & $past(set_evt)) == $past(set_evt)));

    // R3: a lone clear transition drops its status bit
    assert_clear_drops_R3: assert property (@(posedge uart_clk) disable iff (!rst_n)
        ((clr_evt & ~set_evt) != '0) |=> ((raw_stat & $past(clr_evt & ~set_evt)) == '0));

    // R3: status falls only where a clear transition was seen
    assert_fall_needs_clear_R3: assert property (@(posedge uart_clk) disable iff (!rst_n)
        (($past(raw_stat) & ~raw_stat & ~$past(clr_evt)) == '0));

    // R6: set and clear in one cycle keep the status at 1
    assert_set_wins_R6: assert property (@(posedge uart_clk) disable iff (!rst_n)
        ((set_evt & clr_evt) != '0) |=> ((raw_stat & $past(set_evt & clr_evt)) == $past(set_evt & clr_evt)));

    // R5: clear register address reads zeros
    assert_clr_reads_zero_R5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (addr == ADR_CLR) |-> (rdata == '0));

    // R9: interrupt only with some raw status pending
    assert_irq_needs_raw_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
        irq |-> (raw_stat != '0));

endmodule

bind modem_irq_clear msc_checker #(.REG_W(REG_W)) u_chk (
    .bus_clk  (bus_clk),
    .uart_clk (uart_clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rdata    (rdata),
    .raw_stat (raw_stat),
    .irq      (irq),
    .set_evt  (set_evt),
    .clr_evt  (clr_evt)
);

// File: tb/tb_modem_irq_clear.sv
module tb_modem_irq_clear;
    import msc_pkg::*;

    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] CTS_M = 8'h02;

    logic             bus_clk = 1'b0;
    logic             uart_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cts_i = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       addr = 2'd0;
    logic [REG_W-1:0] wdata = '0;
    logic [REG_W-1:0] rdata;
    logic [REG_W-1:0] raw_stat;
    logic [REG_W-1:0] masked_stat;
    logic             irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #5  bus_clk  = ~bus_clk;   // 100 MHz
    always #20 uart_clk = ~uart_clk;  // quarter rate, edges offset from bus edges

    modem_irq_clear #(.REG_W(REG_W), .CTS_BIT(1), .SYNC_STAGES(2)) dut (
        .bus_clk     (bus_clk),
        .uart_clk    (uart_clk),
        .rst_n       (rst_n),
        .cts_i       (cts_i),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .raw_stat    (raw_stat),
        .masked_stat (masked_stat),
        .irq         (irq)
    );

    task automatic check(input string tag, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [REG_W-1:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [REG_W-1:0] d);
        @(negedge bus_clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (12) @(posedge uart_clk);
        #3;
    endtask

    task automatic toggle_cts();
        cts_i = ~cts_i;
        settle();
    endtask

    task automatic t_reset();
        logic [REG_W-1:0] v;
        for (int a = 0; a < 4; a++) begin
            bus_rd(2'(a), v);
            check("R1 reset register read", v, '0);
        end
        check("R1 reset raw_stat", raw_stat, '0);
        check("R1 reset irq", {7'd0, irq}, '0);
    endtask

    task automatic t_edges_and_clear();
        logic [REG_W-1:0] v;
        toggle_cts();                               // rising
        bus_rd(ADR_RAW, v);
        check("R2 rising edge sets raw", v, CTS_M);
        check("R2 raw_stat port", raw_stat, CTS_M);
        bus_wr(ADR_CLR, CTS_M);
        settle();
        bus_rd(ADR_RAW, v);
        check("R3 write 1 clears raw", v, '0);
        toggle_cts();                               // falling
        bus_rd(ADR_RAW, v);
        check("R2 falling edge sets raw", v, CTS_M);
        bus_wr(ADR_CLR, CTS_M);                     // no 0 written first
        settle();
        bus_rd(ADR_RAW, v);
        check("R4 latch self-reset allows second clear", v, '0);
        bus_wr(ADR_CLR, 8'hFF);
        bus_rd(ADR_CLR, v);
        check("R5 clear register reads zero", v, '0);
    endtask

    task automatic t_mask();
        logic [REG_W-1:0] v;
        toggle_cts();
        check("R9 irq low while masked", {7'd0, irq}, '0);
        bus_rd(ADR_MSK_STAT, v);
        check("R9 masked status zero with mask off", v, '0);
        bus_wr(ADR_MASK, 8'hFF);
        bus_rd(ADR_MASK, v);
        check("R9 mask keeps only bit 1", v, CTS_M);
        bus_rd(ADR_MSK_STAT, v);
        check("R9 masked status read", v, CTS_M);
        check("R9 masked_stat port", masked_stat, CTS_M);
        check("R9 irq high", {7'd0, irq}, 8'd1);
        bus_wr(ADR_CLR, CTS_M);
        settle();
        check("R9 irq low after clear", {7'd0, irq}, '0);
        bus_wr(ADR_MASK, 8'h00);
    endtask

    task automatic t_race_and_recovery();
        logic [REG_W-1:0] v;
        toggle_cts();                               // status = 1, latch = 0
        // CTS change and clear write land between the same two UART edges
        @(posedge uart_clk); #1;
        cts_i = ~cts_i;
        bus_wr(ADR_CLR, CTS_M);
        settle();
        bus_rd(ADR_RAW, v);
        check("R6 set wins over clear", v, CTS_M);
        bus_wr(ADR_CLR, CTS_M);
        settle();
        bus_rd(ADR_RAW, v);
        check("R6 repeated write 1 stays stuck", v, CTS_M);
        // Zero held only between two UART edges
        @(posedge uart_clk); #1;
        bus_wr(ADR_CLR, 8'h00);
        bus_wr(ADR_CLR, CTS_M);
        settle();
        bus_rd(ADR_RAW, v);
        check("R8 short zero missed, status stays", v, CTS_M);
        // Proper recovery: zero across several UART edges, then one
        bus_wr(ADR_CLR, 8'h00);
        repeat (3) @(posedge uart_clk);
        bus_wr(ADR_CLR, CTS_M);
        settle();
        bus_rd(ADR_RAW, v);
        check("R7 zero-then-one recovers clear", v, '0);
        check("R7 raw_stat port after recovery", raw_stat, '0);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #103;
        rst_n = 1'b1;
        settle();
        t_reset();
        t_edges_and_clear();
        t_mask();
        t_race_and_recovery();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule